// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the software-facing command register for sending inter-processor interrupts. A 32-bit register bus reaches two words. The high word holds the destination identifier. The low word holds the vector, the delivery mode, the trigger and level bits and the destination shorthand. Writing the low word is the send command itself. The decoded fields then go out on a valid/ready message interface. If the shorthand targets only the sender, the message goes to a local-accept strobe and the external interface is not used.

Software polls a delivery-status bit in the low word. It reads 1 from the write until the message is taken, and it must read 0 before the next command is written. A low-word write made while a message is still pending is dropped and raises a sticky error flag. For a startup message the vector holds a 4 KiB page number, and the block also presents the full start address it stands for.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, msgValid, localAccept and sendErr are 0, and both words read back as 0.
- R2: A write to byte offset 0x310 stores bits 31:24 as the destination identifier, which reads back in the same position. This write never starts a message and never changes the delivery-status bit.
- R3: A write to byte offset 0x300 while idle sends a message. The fields are decoded as vector = bits 7:0, delivery mode = bits 10:8 (5 = INIT, 6 = STARTUP), level = bit 14 (1 assert, 0 deassert), trigger = bit 15 (1 level) and shorthand = bits 19:18. msgValid rises on the clock edge that takes the write.
- R4: The delivery-status bit (bit 12 of the low word) reads 1 from the write until the edge where msgValid and msgReady are both high. While msgReady is low, msgValid and all message fields hold steady.
- R5: With shorthand 0 (explicit), msgDest equals the stored destination identifier. With shorthand 2 (all including self) or 3 (all excluding self), msgDest is all ones.
- R6: With shorthand 1 (self only), msgValid stays 0. localAccept pulses for exactly one cycle, starting the cycle after the write, and the delivery-status bit clears at the end of that cycle.
- R7: A low-word write while delivery status is 1 leaves the pending message unchanged and sets sendErr. sendErr stays set until reset.
- R8: Bits 17:16 of the low word (remote read status) read as 0 (invalid). Bits 31:20, 13 and 11 of the low word and bits 23:0 of the high word also read as 0.
- R9: When the delivery mode is STARTUP (6), msgStartAddr equals the vector times 4096. For any other mode it is 0.
- R10: The destination goes out as it was when the low word was written. A high-word write during a pending message changes the read-back value but not msgDest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read enable |
| regAddr | input | 12 | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data (combinational, 0 when not reading) |
| msgValid | output | 1 | Outgoing message valid |
| msgReady | input | 1 | Outgoing message accepted |
| msgVector | output | 8 | Message vector |
| msgMode | output | 3 | Delivery mode |
| msgDest | output | 8 | Effective destination |
| msgShorthand | output | 2 | Destination shorthand |
| msgLevel | output | 1 | Level (assert/deassert) |
| msgTrigger | output | 1 | Trigger mode (1 = level) |
| msgStartAddr | output | 20 | Startup start address (vector × 4096) |
| localAccept | output | 1 | Self-targeted message taken locally |
| sendErr | output | 1 | Sticky illegal-send flag |

## Verification
The hardest state to reach is a message held pending while other bus traffic arrives at it. The bench reaches it by keeping msgReady low for several cycles after a send. In that window it writes the low word again and overwrites the high word. It then checks that the outgoing fields, including the destination snapshot, stay the same while the error flag and the read-back destination change. The self-only path is checked on the cycle after the write, where localAccept must be high and msgValid low.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;
  localparam int ID_W   = 8;
  localparam int DATA_W = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int START_W = VEC_W + PAGE_SHIFT;

  localparam logic [1:0] SH_EXPLICIT = 2'd0;
  localparam logic [1:0] SH_SELF     = 2'd1;
  localparam logic [1:0] SH_ALL      = 2'd2;
  localparam logic [1:0] SH_OTHERS   = 2'd3;

  localparam logic [MODE_W-1:0] MODE_INIT    = 3'd5;
  localparam logic [MODE_W-1:0] MODE_STARTUP = 3'd6;

  typedef struct packed {
    logic launch;
    logic loadHi;
  } ipiStrobes_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 12'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 12'h310
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              msgReady,
  input  logic              selfMode,
  output ipiStrobes_t       strobes,
  output logic              busy,
  output logic              msgValid,
  output logic              localAccept,
  output logic              sendErr
);
  logic wrLow;
  logic wrHigh;
  logic done;

  assign wrLow  = regWrEn && (regAddr == LOW_OFF);
  assign wrHigh = regWrEn && (regAddr == HIGH_OFF);

  assign strobes.launch = wrLow && !busy;
  assign strobes.loadHi = wrHigh;

  assign msgValid    = busy && !selfMode;
  assign localAccept = busy && selfMode;
  assign done        = localAccept || (msgValid && msgReady);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sendErr <= 1'b0;
    end else begin
      if (strobes.launch) busy <= 1'b1;
      else if (done)      busy <= 1'b0;
      if (wrLow && busy)  sendErr <= 1'b1;
    end
  end
endmodule

// File: rtl/ipi_dpath.sv
module ipi_dpath
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 12'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 12'h310
) (
  input  logic               clk,
  input  logic               rstN,
  input  ipiStrobes_t        strobes,
  input  logic               busy,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               selfMode,
  output logic [VEC_W-1:0]   msgVector,
  output logic [MODE_W-1:0]  msgMode,
  output logic [ID_W-1:0]    msgDest,
  output logic [1:0]         msgShorthand,
  output logic               msgLevel,
  output logic               msgTrigger,
  output logic [START_W-1:0] msgStartAddr
);
  logic [VEC_W-1:0]  vecQ;
  logic [MODE_W-1:0] modeQ;
  logic              levelQ;
  logic              trigQ;
  logic [1:0]        shQ;
  logic [ID_W-1:0]   hiDestQ;
  logic [ID_W-1:0]   sentDestQ;
  logic [DATA_W-1:0] lowWord;
  logic [DATA_W-1:0] highWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ      <= '0;
      modeQ     <= '0;
      levelQ    <= 1'b0;
      trigQ     <= 1'b0;
      shQ       <= SH_EXPLICIT;
      hiDestQ   <= '0;
      sentDestQ <= '0;
    end else begin
      if (strobes.loadHi) hiDestQ <= regWrData[31:24];
      if (strobes.launch) begin
        vecQ      <= regWrData[7:0];
        modeQ     <= regWrData[10:8];
        levelQ    <= regWrData[14];
        trigQ     <= regWrData[15];
        shQ       <= regWrData[19:18];
        sentDestQ <= hiDestQ;
      end
    end
  end

  assign selfMode     = (shQ == SH_SELF);
  assign msgVector    = vecQ;
  assign msgMode      = modeQ;
  assign msgLevel     = levelQ;
  assign msgTrigger   = trigQ;
  assign msgShorthand = shQ;
  assign msgDest      = (shQ == SH_EXPLICIT) ? sentDestQ : {ID_W{1'b1}};
  assign msgStartAddr = (modeQ == MODE_STARTUP) ? {vecQ, {PAGE_SHIFT{1'b0}}} : '0;

  always_comb begin
    lowWord        = '0;
    lowWord[7:0]   = vecQ;
    lowWord[10:8]  = modeQ;
    lowWord[12]    = busy;
    lowWord[14]    = levelQ;
    lowWord[15]    = trigQ;
    lowWord[19:18] = shQ;
    highWord        = '0;
    highWord[31:24] = hiDestQ;
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      if (regAddr == LOW_OFF)       regRdData = lowWord;
      else if (regAddr == HIGH_OFF) regRdData = highWord;
    end
  end
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 12'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 12'h310
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [7:0]         msgVector,
  output logic [2:0]         msgMode,
  output logic [7:0]         msgDest,
  output logic [1:0]         msgShorthand,
  output logic               msgLevel,
  output logic               msgTrigger,
  output logic [19:0]        msgStartAddr,
  output logic               localAccept,
  output logic               sendErr
);
  ipiStrobes_t strobes;
  logic        busy;
  logic        selfMode;

  ipi_ctrl #(.ADDR_W(ADDR_W), .LOW_OFF(LOW_OFF), .HIGH_OFF(HIGH_OFF)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .msgReady(msgReady), .selfMode(selfMode), .strobes(strobes), .busy(busy),
    .msgValid(msgValid), .localAccept(localAccept), .sendErr(sendErr)
  );

  ipi_dpath #(.ADDR_W(ADDR_W), .LOW_OFF(LOW_OFF), .HIGH_OFF(HIGH_OFF)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .selfMode(selfMode),
    .msgVector(msgVector), .msgMode(msgMode), .msgDest(msgDest),
    .msgShorthand(msgShorthand), .msgLevel(msgLevel), .msgTrigger(msgTrigger),
    .msgStartAddr(msgStartAddr)
  );
endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        msgValid,
  input logic        msgReady,
  input logic [7:0]  msgVector,
  input logic [2:0]  msgMode,
  input logic [7:0]  msgDest,
  input logic [1:0]  msgShorthand,
  input logic        localAccept,
  input logic        sendErr
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgVector) && $stable(msgMode) && $stable(msgDest)); // R4
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady |=> !msgValid); // R4
  AST_SELF_LOCAL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    localAccept |-> !msgValid && msgShorthand == 2'd1); // R6
  AST_LOCAL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    localAccept |=> !localAccept); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    sendErr |=> sendErr); // R7
  AST_BCAST_DEST: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgShorthand[1] |-> msgDest == 8'hFF); // R5
endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk chk_i (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReady(msgReady),
  .msgVector(msgVector), .msgMode(msgMode), .msgDest(msgDest),
  .msgShorthand(msgShorthand), .localAccept(localAccept), .sendErr(sendErr)
);

// File: tb/ipi_cmd_reg_tb_top.sv
module ipi_cmd_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [7:0]  msgVector;
  logic [2:0]  msgMode;
  logic [7:0]  msgDest;
  logic [1:0]  msgShorthand;
  logic        msgLevel;
  logic        msgTrigger;
  logic [19:0] msgStartAddr;
  logic        localAccept;
  logic        sendErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [11:0] LO = 12'h300;
  localparam logic [11:0] HI = 12'h310;

  always #10 clk = ~clk;

  ipi_cmd_reg dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .msgValid(msgValid), .msgReady(msgReady), .msgVector(msgVector),
    .msgMode(msgMode), .msgDest(msgDest), .msgShorthand(msgShorthand),
    .msgLevel(msgLevel), .msgTrigger(msgTrigger), .msgStartAddr(msgStartAddr),
    .localAccept(localAccept), .sendErr(sendErr)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    regRdEn = 1'b0;
  endtask

  task automatic finish_send();
    @(negedge clk);
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1", "msgValid", 32'(msgValid), 0);
    check("R1", "localAccept", 32'(localAccept), 0);
    check("R1", "sendErr", 32'(sendErr), 0);
    rd(LO, d); check("R1", "low word", d, 0);
    rd(HI, d); check("R1", "high word", d, 0);
  endtask

  task automatic t_high_only();
    logic [31:0] d;
    wr(HI, 32'h2A00_00FF);
    rd(HI, d); check("R2", "high readback", d, 32'h2A00_0000);
    check("R2", "no launch", 32'(msgValid), 0);
    rd(LO, d); check("R2", "status idle", 32'(d[12]), 0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    wr(LO, 32'h0000_C041);
    check("R3", "valid", 32'(msgValid), 1);
    check("R3", "vector", 32'(msgVector), 32'h41);
    check("R3", "mode", 32'(msgMode), 0);
    check("R3", "level", 32'(msgLevel), 1);
    check("R3", "trigger", 32'(msgTrigger), 1);
    check("R5", "explicit dest", 32'(msgDest), 32'h2A);
    rd(LO, d); check("R4", "status busy", d, 32'h0000_D041);
    check("R8", "remote status", 32'(d[17:16]), 0);
    repeat (3) @(negedge clk);
    check("R4", "held valid", 32'(msgValid), 1);
    wr(LO, 32'h0008_06FF);
    check("R7", "sendErr", 32'(sendErr), 1);
    check("R7", "vector kept", 32'(msgVector), 32'h41);
    check("R7", "mode kept", 32'(msgMode), 0);
    wr(HI, 32'h5500_0000);
    rd(HI, d); check("R10", "high readback new", d, 32'h5500_0000);
    check("R10", "dest snapshot", 32'(msgDest), 32'h2A);
    finish_send();
    check("R4", "valid dropped", 32'(msgValid), 0);
    rd(LO, d); check("R4", "status clear", d, 32'h0000_C041);
    check("R7", "sendErr sticky", 32'(sendErr), 1);
  endtask

  task automatic t_init_all();
    wr(LO, 32'h0008_8500);
    check("R5", "all-incl dest", 32'(msgDest), 32'hFF);
    check("R3", "shorthand", 32'(msgShorthand), 2);
    check("R3", "INIT mode", 32'(msgMode), 5);
    check("R3", "deassert", 32'(msgLevel), 0);
    check("R9", "no start addr", 32'(msgStartAddr), 0);
    finish_send();
  endtask

  task automatic t_startup();
    wr(LO, 32'h0000_0607);
    check("R9", "start addr", 32'(msgStartAddr), 32'h7000);
    check("R5", "dest new", 32'(msgDest), 32'h55);
    finish_send();
  endtask

  task automatic t_self();
    logic [31:0] d;
    wr(LO, 32'h0004_0030);
    check("R6", "localAccept", 32'(localAccept), 1);
    check("R6", "no external", 32'(msgValid), 0);
    @(negedge clk);
    check("R6", "pulse over", 32'(localAccept), 0);
    check("R6", "still no external", 32'(msgValid), 0);
    rd(LO, d); check("R6", "status clear", 32'(d[12]), 0);
  endtask

  task automatic t_others();
    wr(LO, 32'h000C_0022);
    check("R5", "all-excl dest", 32'(msgDest), 32'hFF);
    check("R3", "vector", 32'(msgVector), 32'h22);
    finish_send();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_high_only();
    t_pending();
    t_init_all();
    t_startup();
    t_self();
    t_others();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule